// File: doc/BRIEF.md
# Masked blend SAD engine

This engine scores how well a compound prediction matches a source block. The prediction is never stored. Each predicted pixel is built inside the engine from two reference sample streams, which are mixed by a weight mask sampled per pixel. The mask weight runs from 0 to 64 and the mix is rounded to 6 fractional bits. The absolute difference between each mixed pixel and the matching source pixel is summed over the whole block. The block sum is then rescaled by 1/64, with rounding, to give the cost.

A caller pulses `start_i` to load the block shape, the predictor swap flag and the sample depth. It then streams the block in raster order, four pixels per beat, over a valid/ready handshake. One cycle after the last beat is accepted, `done_o` pulses and `cost_o` holds the result. The input stays stalled until the next start. Address generation, stride handling and the search loop are left to the surrounding logic.

Top module: `mblend_sad`

## Requirements
- R1: Each mixed pixel equals (w*A + (64-w)*B + 32) >> 6, where A and B are the two predictor samples and w is the effective mask weight.
- R2: A mask value above 64 is treated as 64.
- R3: With `cfg_invert_i` set at start, the weight w applies to B and 64-w applies to A. This equals swapping the two predictors.
- R4: Each beat carries 4 pixels. Pixel k of a beat sits at bits [k*16 +: 16] of each sample bus and bits [k*8 +: 8] of the mask bus. Beats run along a row, and rows follow one another. The cost is (S + 31) >> 6, where S is the sum of |mixed - source| over all width*height pixels.
- R5: With `cfg_hbd_i` = 1, all 16 bits of each sample are used. With `cfg_hbd_i` = 0, bits 15..8 of source and predictor samples are ignored.
- R6: `done_o` is high for exactly one cycle, the cycle after the last beat is accepted. `cost_o` carries the new cost from that cycle and holds it until the next `done_o`.
- R7: `in_ready_o` is low after reset and from the done cycle until the next start. Beats offered while it is low do not change the next cost. `in_ready_o` is high from the cycle after a start.
- R8: A start clears the running sum and loads a new configuration. A beat offered in the same cycle as a start is discarded. Any block in progress is abandoned without a `done_o`.
- R9: While in reset and just after it, `done_o` = 0, `in_ready_o` = 0 and `cost_o` = 0.
- R10: Width and height are each any multiple of 4 from 4 to 128, square or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block and load the configuration |
| cfg_width_i | input | 8 | Block width in pixels |
| cfg_height_i | input | 8 | Block height in rows |
| cfg_invert_i | input | 1 | Swap the weights applied to the two predictors |
| cfg_hbd_i | input | 1 | 1: 16-bit samples, 0: 8-bit samples |
| in_valid_i | input | 1 | Beat valid |
| in_ready_o | output | 1 | Beat accepted when high together with valid |
| src_i | input | 64 | Four source samples |
| pred_a_i | input | 64 | Four predictor A samples |
| pred_b_i | input | 64 | Four predictor B samples |
| mask_i | input | 32 | Four mask weights |
| done_o | output | 1 | One-cycle pulse when the cost is ready |
| cost_o | output | 26 | Scaled block cost |

## Verification
A start request and a beat acceptance can meet in one cycle, including on the final beat of a block. The bench streams a block of pixels whose differences are all 255 and raises start together with its last beat. It then checks that no done pulse follows and that the input is ready again. A second, small block is then streamed, and its cost must show only that block's contribution. Any leaked beat from the abandoned block would push the cost far above the expected value of 1.

// File: rtl/mblend_pkg.sv
package mblend_pkg;
   // fractional bits of the blend weight; full weight is 1 << BLEND_SH
   localparam int unsigned BLEND_SH = 6;
   localparam int unsigned W_ONE    = 1 << BLEND_SH;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/mblend_lane.sv
// One pixel lane: clamp weight, mix predictors, absolute difference to source.
module mblend_lane
   import mblend_pkg::*;
#(
   parameter int unsigned SMP_W = 16,
   parameter int unsigned MSK_W = 8
) (
   input  logic             hbd_i,
   input  logic             inv_i,
   input  logic [SMP_W-1:0] src_i,
   input  logic [SMP_W-1:0] pa_i,
   input  logic [SMP_W-1:0] pb_i,
   input  logic [MSK_W-1:0] msk_i,
   output logic [SMP_W-1:0] absd_o
);
   localparam int unsigned WT_W  = BLEND_SH + 1;
   localparam int unsigned MIX_W = SMP_W + BLEND_SH + 1;

   logic [SMP_W-1:0] a_eff, b_eff, s_eff;
   logic [WT_W-1:0]  m_cl, wa, wb;
   logic [MIX_W-1:0] mix;
   logic [SMP_W-1:0] blend;

   // sample narrowing variant: only present when samples are wider than 8 bits
   generate
      if (SMP_W > 8) begin : g_narrow
         always_comb begin
            a_eff = hbd_i ? pa_i  : {{(SMP_W-8){1'b0}}, pa_i[7:0]};
            b_eff = hbd_i ? pb_i  : {{(SMP_W-8){1'b0}}, pb_i[7:0]};
            s_eff = hbd_i ? src_i : {{(SMP_W-8){1'b0}}, src_i[7:0]};
         end
      end else begin : g_plain
         always_comb begin
            a_eff = pa_i;
            b_eff = pb_i;
            s_eff = src_i;
         end
      end
   endgenerate

   always_comb begin
      m_cl  = (msk_i > MSK_W'(W_ONE)) ? WT_W'(W_ONE) : WT_W'(msk_i);
      wa    = inv_i ? (WT_W'(W_ONE) - m_cl) : m_cl;
      wb    = WT_W'(W_ONE) - wa;
      mix   = MIX_W'(wa) * MIX_W'(a_eff) + MIX_W'(wb) * MIX_W'(b_eff)
            + MIX_W'(W_ONE / 2);
      blend = SMP_W'(mix >> BLEND_SH);
      absd_o = (blend >= s_eff) ? (blend - s_eff) : (s_eff - blend);
   end
endmodule

// File: rtl/mblend_seq.sv
// Beat sequencer: tracks column beat and row inside the block.
module mblend_seq
   import mblend_pkg::*;
#(
   parameter int unsigned DIM_W = 8,
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DIM_W-1:0] width_i,
   input  logic [DIM_W-1:0] height_i,
   input  logic             fire_i,
   output logic             running_o,
   output logic             last_o
);
   localparam int unsigned LSH = $clog2(LANES);

   seq_state_e       state_q;
   logic [DIM_W-1:0] col_q, row_q, col_max_q, row_max_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         col_q     <= '0;
         row_q     <= '0;
         col_max_q <= '0;
         row_max_q <= '0;
      end else if (start_i) begin
         state_q   <= SEQ_RUN;
         col_q     <= '0;
         row_q     <= '0;
         col_max_q <= DIM_W'((width_i >> LSH) - DIM_W'(1));
         row_max_q <= DIM_W'(height_i - DIM_W'(1));
      end else if (fire_i) begin
         if (last_o) begin
            state_q <= SEQ_IDLE;
         end else if (col_q == col_max_q) begin
            col_q <= '0;
            row_q <= row_q + DIM_W'(1);
         end else begin
            col_q <= col_q + DIM_W'(1);
         end
      end
   end

   assign running_o = (state_q == SEQ_RUN);
   assign last_o    = running_o && (col_q == col_max_q) && (row_q == row_max_q);
endmodule

// File: rtl/mblend_sad.sv
module mblend_sad
   import mblend_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned SMP_W = 16,
   parameter int unsigned MSK_W = 8,
   parameter int unsigned DIM_W = 8,
   parameter int unsigned ACC_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [DIM_W-1:0]          cfg_width_i,
   input  logic [DIM_W-1:0]          cfg_height_i,
   input  logic                      cfg_invert_i,
   input  logic                      cfg_hbd_i,
   input  logic                      in_valid_i,
   output logic                      in_ready_o,
   input  logic [LANES*SMP_W-1:0]    src_i,
   input  logic [LANES*SMP_W-1:0]    pred_a_i,
   input  logic [LANES*SMP_W-1:0]    pred_b_i,
   input  logic [LANES*MSK_W-1:0]    mask_i,
   output logic                      done_o,
   output logic [ACC_W-BLEND_SH-1:0] cost_o
);
   localparam int unsigned BEAT_W = SMP_W + $clog2(LANES) + 1;
   localparam int unsigned COST_W = ACC_W - BLEND_SH;

   // elaboration-time parameter checks
   generate
      if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two");
      end
      if (MSK_W < BLEND_SH + 1) begin : g_bad_msk
         $error("MSK_W too narrow to carry a full weight");
      end
      if (SMP_W < 8) begin : g_bad_smp
         $error("SMP_W must be at least 8");
      end
      if (ACC_W < 2 * SMP_W - 2) begin : g_bad_acc
         $error("ACC_W too narrow for the largest block");
      end
   endgenerate

   logic              running, last_beat, fire;
   logic              inv_q, hbd_q;
   logic [SMP_W-1:0]  lane_d [LANES];
   logic [BEAT_W-1:0] beat_sum;
   logic [ACC_W-1:0]  acc_q, acc_nxt, acc_rnd;
   logic              done_q;
   logic [COST_W-1:0] cost_q;

   assign fire = in_valid_i && running && !start_i;

   mblend_seq #(.DIM_W(DIM_W), .LANES(LANES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .width_i  (cfg_width_i),
      .height_i (cfg_height_i),
      .fire_i   (fire),
      .running_o(running),
      .last_o   (last_beat)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         mblend_lane #(.SMP_W(SMP_W), .MSK_W(MSK_W)) u_lane (
            .hbd_i (hbd_q),
            .inv_i (inv_q),
            .src_i (src_i[k*SMP_W +: SMP_W]),
            .pa_i  (pred_a_i[k*SMP_W +: SMP_W]),
            .pb_i  (pred_b_i[k*SMP_W +: SMP_W]),
            .msk_i (mask_i[k*MSK_W +: MSK_W]),
            .absd_o(lane_d[k])
         );
      end
   endgenerate

   always_comb begin
      beat_sum = '0;
      for (int k = 0; k < LANES; k++) begin
         beat_sum = beat_sum + BEAT_W'(lane_d[k]);
      end
      acc_nxt = acc_q + ACC_W'(beat_sum);
      acc_rnd = acc_nxt + ACC_W'(W_ONE / 2 - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_q  <= 1'b0;
         hbd_q  <= 1'b0;
         acc_q  <= '0;
         done_q <= 1'b0;
         cost_q <= '0;
      end else begin
         done_q <= fire && last_beat;
         if (start_i) begin
            inv_q <= cfg_invert_i;
            hbd_q <= cfg_hbd_i;
            acc_q <= '0;
         end else if (fire) begin
            acc_q <= acc_nxt;
            if (last_beat) begin
               cost_q <= COST_W'(acc_rnd >> BLEND_SH);
            end
         end
      end
   end

   assign in_ready_o = running;
   assign done_o     = done_q;
   assign cost_o     = cost_q;
endmodule

// File: rtl/mblend_sad_chk.sv
module mblend_sad_chk #(
   parameter int unsigned COST_W = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              in_valid_i,
   input logic              in_ready_o,
   input logic              done_o,
   input logic [COST_W-1:0] cost_o
);
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                         // R6
   AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(in_valid_i && in_ready_o && !start_i));     // R6
   AST_COST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(cost_o));                                // R6
   AST_STALL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !in_ready_o);                                     // R7
   AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> in_ready_o);                                     // R7
   AST_START_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_o);                                        // R8
endmodule

bind mblend_sad mblend_sad_chk #(.COST_W(ACC_W - mblend_pkg::BLEND_SH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .in_valid_i(in_valid_i),
   .in_ready_o(in_ready_o),
   .done_o    (done_o),
   .cost_o    (cost_o)
);

// File: tb/mblend_sad_bench.sv
module mblend_sad_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 4;
   localparam int SMP_W = 16;
   localparam int MSK_W = 8;
   localparam int DIM_W = 8;
   localparam int ACC_W = 32;
   localparam int COST_W = ACC_W - 6;
   localparam int NV = 10;

   // vector table: width, height, invert, hbd, A, B, mask, source, expected cost
   localparam int T_W  [NV] = '{4,   8,   4,   4,   16,    4,     32, 128,   4,   4};
   localparam int T_H  [NV] = '{4,   4,   4,   8,   4,     4,     8,  128,   128, 4};
   localparam int T_I  [NV] = '{0,   0,   0,   1,   0,     0,     0,  0,     1,   0};
   localparam int T_D  [NV] = '{0,   0,   0,   0,   1,     0,     0,  1,     0,   0};
   localparam int T_A  [NV] = '{200, 255, 10,  200, 60000, 'h1FF, 1,  65535, 0,   3};
   localparam int T_B  [NV] = '{100, 0,   250, 100, 1000,  'h100, 3,  65535, 255, 3};
   localparam int T_M  [NV] = '{32,  64,  200, 16,  40,    64,    32, 0,     0,   0};
   localparam int T_S  [NV] = '{0,   0,   0,   100, 0,     'h200, 0,  0,     5,   0};
   localparam int T_X  [NV] = '{37,  127, 2,   37,  37875, 64,    8,  16776960, 40, 1};
   localparam string T_R [NV] = '{"R1", "R1", "R2", "R3", "R5", "R5", "R10", "R10", "R3", "R4"};

   logic                   clk, rst_n, start, inv, hbd, vld;
   logic [DIM_W-1:0]       wid, hgt;
   logic                   rdy, done;
   logic [LANES*SMP_W-1:0] src, pa, pb;
   logic [LANES*MSK_W-1:0] msk;
   logic [COST_W-1:0]      cost;

   int n_chk = 0;
   int n_fail = 0;
   int pat_mode = 0;
   int ca, cb, cm, cs;

   mblend_sad u_mblend_sad (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_width_i(wid),
      .cfg_height_i(hgt), .cfg_invert_i(inv), .cfg_hbd_i(hbd),
      .in_valid_i(vld), .in_ready_o(rdy), .src_i(src), .pred_a_i(pa),
      .pred_b_i(pb), .mask_i(msk), .done_o(done), .cost_o(cost)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int gen(input int sel, input int p);
      if (pat_mode == 0) begin
         case (sel)
            0: return ca;
            1: return cb;
            2: return cm;
            default: return cs;
         endcase
      end
      case (sel)
         0: return (p * 53 + 7) % 65536;
         1: return (p * 29 + 200) % 65536;
         2: return (p * 7) % 90;
         default: return (p * 113 + 5) % 65536;
      endcase
   endfunction

   // independent model of one pixel cost from the requirements
   function automatic int ref_diff(input int a, input int b, input int m, input int s,
                                   input int iv, input int hd);
      int aa = a, bb = b, ss = s, mm = m, wa, bl;
      if (hd == 0) begin aa = a & 255; bb = b & 255; ss = s & 255; end
      if (mm > 64) mm = 64;
      wa = (iv != 0) ? 64 - mm : mm;
      bl = (wa * aa + (64 - wa) * bb + 32) >> 6;
      return (bl > ss) ? bl - ss : ss - bl;
   endfunction

   task automatic do_start(input int w, input int h, input int iv, input int hd);
      @(negedge clk);
      wid = DIM_W'(w); hgt = DIM_W'(h); inv = iv[0]; hbd = hd[0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic set_beat(input int w, input int r, input int c);
      for (int k = 0; k < LANES; k++) begin
         int p = r * w + c * LANES + k;
         pa[k*SMP_W +: SMP_W]  = SMP_W'(gen(0, p));
         pb[k*SMP_W +: SMP_W]  = SMP_W'(gen(1, p));
         msk[k*MSK_W +: MSK_W] = MSK_W'(gen(2, p));
         src[k*SMP_W +: SMP_W] = SMP_W'(gen(3, p));
      end
   endtask

   // streams a block; returns with outputs sampled one cycle after the last beat
   task automatic feed(input int w, input int h, input int iv, input int hd, output longint sum);
      sum = 0;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w / LANES; c++) begin
            @(negedge clk);
            set_beat(w, r, c);
            for (int k = 0; k < LANES; k++) begin
               int p = r * w + c * LANES + k;
               sum += ref_diff(gen(0, p), gen(1, p), gen(2, p), gen(3, p), iv, hd);
            end
            vld = 1'b1;
            @(posedge clk);
         end
      end
      @(negedge clk);
      vld = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      longint sum;
      logic [COST_W-1:0] held;
      rst_n = 1'b0; start = 1'b0; vld = 1'b0; inv = 1'b0; hbd = 1'b0;
      wid = '0; hgt = '0; src = '0; pa = '0; pb = '0; msk = '0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && rdy == 1'b0 && cost == '0, "R9", longint'({done, rdy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && rdy == 1'b0 && cost == '0, "R9", longint'(cost), 0);

      // table walk, constant pixels per block
      for (int i = 0; i < NV; i++) begin
         pat_mode = 0;
         ca = T_A[i]; cb = T_B[i]; cm = T_M[i]; cs = T_S[i];
         do_start(T_W[i], T_H[i], T_I[i], T_D[i]);
         chk(rdy == 1'b1, "R7", longint'(rdy), 1);
         feed(T_W[i], T_H[i], T_I[i], T_D[i], sum);
         chk(done == 1'b1, "R6", longint'(done), 1);
         chk(longint'(cost) == longint'(T_X[i]), T_R[i], longint'(cost), longint'(T_X[i]));
         @(negedge clk);
         chk(done == 1'b0 && rdy == 1'b0, "R6", longint'({done, rdy}), 0);
      end

      // beats offered after done are ignored; cost held
      held = cost;
      vld = 1'b1; pa = '1; pb = '1; src = '0; msk = '0;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk(rdy == 1'b0 && done == 1'b0 && cost == held, "R7", longint'(cost), longint'(held));
      end
      vld = 1'b0;

      // varying pixels, 16-bit samples, clamped masks
      pat_mode = 1;
      do_start(8, 8, 0, 1);
      feed(8, 8, 0, 1, sum);
      chk(done == 1'b1 && longint'(cost) == ((sum + 31) >> 6), "R4", longint'(cost), (sum + 31) >> 6);

      // varying pixels, 8-bit mode, inverted, width 12
      do_start(12, 8, 1, 0);
      feed(12, 8, 1, 0, sum);
      chk(done == 1'b1 && longint'(cost) == ((sum + 31) >> 6), "R10", longint'(cost), (sum + 31) >> 6);

      // start collides with the final beat of a block
      pat_mode = 0;
      ca = 255; cb = 255; cm = 0; cs = 0;
      do_start(4, 4, 0, 0);
      for (int r = 0; r < 3; r++) begin
         @(negedge clk);
         set_beat(4, r, 0);
         vld = 1'b1;
         @(posedge clk);
      end
      @(negedge clk);
      set_beat(4, 3, 0);
      vld = 1'b1; start = 1'b1; wid = 8'd4; hgt = 8'd4; inv = 1'b0; hbd = 1'b0;
      @(negedge clk);
      start = 1'b0; vld = 1'b0;
      chk(done == 1'b0, "R8", longint'(done), 0);
      chk(rdy == 1'b1, "R8", longint'(rdy), 1);
      ca = 3; cb = 3;
      feed(4, 4, 0, 0, sum);
      chk(done == 1'b1 && cost == COST_W'(1), "R8", longint'(cost), 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule